// File: doc/BRIEF.md
# Late-Write Pipelined-Read SRAM Front End

This block is a single-clock synchronous SRAM front end wrapped around a small on-chip array organised as four 9-bit byte lanes. On every rising clock edge it registers the address, the active-low select, the active-low write enable and the active-low byte enables. A read travels a register-to-register pipeline: the array is read on the edge after the command and the result lands in an output register. A write uses a late-write protocol. The command and address are taken on one edge, and the write data is taken on the following edge.

The data output carries an enable flag that stands in for a three-state driver. That flag is gated at once by an active-low output enable and by a sleep input. A deselect turns the output off with the same latency as read data. Each accepted write first sits in a one-entry buffer for a cycle before it reaches the array. A read to that address is served from the buffer lane by lane, so a read always returns the most recent data.

Top module: `lw_sram_ctrl`

## Requirements
- R1: A read command (sel_n=0, we_n=1 at a rising edge k) makes rdata show the word at addr, with rdata_oe=1 while oe_n=0 and sleep=0, from rising edge k+1 until rising edge k+2.
- R2: oe_n only gates rdata_oe, and does so without waiting for a clock. Raising it drops rdata_oe. Lowering it again in the same cycle brings back the same rdata, because the output register is not disturbed.
- R3: A write command (sel_n=0, we_n=0 at edge k) takes its data from wdata at edge k+1, not at edge k.
- R4: be_n is active low and is captured with the write command. be_n[i] controls lane i, which is bits [9*i+8 : 9*i]. Any mix of lanes may be written, and the lanes that are not enabled keep their old contents.
- R5: A write with be_n=4'b1111 is an abort and leaves the array unchanged.
- R6: A deselect (sel_n=1 at edge k) forces rdata_oe=0 from edge k+1 to edge k+2.
- R7: A write command at edge k forces rdata_oe=0 from edge k+1 to edge k+2.
- R8: While sleep=1, rdata_oe is 0 and any command sampled at an edge is ignored. The array contents are kept.
- R9: A read issued on the edge right after a write command to the same address returns the new data, merged lane by lane through that write's byte mask.
- R10: After a synchronous reset (rst_n=0 at an edge), rdata_oe is 0 and no write is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_n | input | 1 | Active-low select; high means deselect |
| we_n | input | 1 | Active-low write enable; high with sel_n low means read |
| be_n | input | 4 | Active-low byte-lane enables for writes |
| addr | input | ADDR_W (8) | Word address |
| wdata | input | 36 | Write data, sampled one edge after its write command |
| oe_n | input | 1 | Active-low output enable; acts without a clock |
| sleep | input | 1 | Sleep request; forces output off and ignores commands |
| rdata | output | 36 | Output register contents |
| rdata_oe | output | 1 | High when rdata would be driven onto the pins |

## Verification
A command sampled at rising edge k has its effect on rdata and rdata_oe after edge k+1. The output stays at that value until edge k+2. Late write data must be present at edge k+1. For every cycle it drives, the bench queues one expected item tagged with the edge count at which it falls due. The item holds the read word or the expected output-off state. A monitor takes the item at the falling edge in the middle of the cycle that follows edge k+1. The oe_n checks are made inside a single cycle, by toggling the pin between two samples, so they need no clock edge.

// File: rtl/lw_sram_pkg.sv
// Package: shared command encoding for the late-write SRAM front end.
// Assumes: every module in the block decodes commands through cmd_e.
package lw_sram_pkg;

    // Decoded command held in the first pipeline stage
    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } cmd_e;

endpackage

// File: rtl/lw_sram_cmd.sv
// Module: command capture stage.
// Registers address, byte enables and the decoded command on each rising
// edge. A command seen while sleep is high, or with select high, is stored
// as CMD_NONE. Assumes synchronous active-low reset.
module lw_sram_cmd
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep,
    input  logic              sel_n,
    input  logic              we_n,
    input  logic [LANES-1:0]  be_n,
    input  logic [ADDR_W-1:0] addr,
    output cmd_e              s1_cmd,
    output logic [ADDR_W-1:0] s1_addr,
    output logic [LANES-1:0]  s1_be_n
);

    // Decode select and write enable into one command, gated by sleep
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_cmd <= CMD_NONE;
        end else if (sleep || sel_n) begin
            s1_cmd <= CMD_NONE;
        end else if (we_n) begin
            s1_cmd <= CMD_READ;
        end else begin
            s1_cmd <= CMD_WRITE;
        end
    end

    // Capture address and byte enables along with the command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_addr <= '0;
            s1_be_n <= '1;
        end else begin
            s1_addr <= addr;
            s1_be_n <= be_n;
        end
    end

    AST_SLEEP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (s1_cmd == CMD_NONE)); // R8

    AST_READ_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !sel_n && we_n) |=> (s1_cmd == CMD_READ)); // R1

endmodule

// File: rtl/lw_sram_wbuf.sv
// Module: one-entry late-write buffer.
// A write command in stage 1 pairs with wdata present on the next edge.
// The buffer then holds address, lane mask and data for one cycle before
// the array commits them. Assumes at most one command per cycle.
module lw_sram_wbuf
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              s1_cmd,
    input  logic [ADDR_W-1:0] s1_addr,
    input  logic [LANES-1:0]  s1_be_n,
    input  logic [DATA_W-1:0] wdata,
    output logic              wb_valid,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [LANES-1:0]  wb_lane_we,
    output logic [DATA_W-1:0] wb_data
);

    // Track whether a late write is pending for commit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid <= 1'b0;
        end else begin
            wb_valid <= (s1_cmd == CMD_WRITE);
        end
    end

    // Take the late data phase together with the command's address and mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_addr    <= '0;
            wb_lane_we <= '0;
            wb_data    <= '0;
        end else if (s1_cmd == CMD_WRITE) begin
            wb_addr    <= s1_addr;
            wb_lane_we <= ~s1_be_n;
            wb_data    <= wdata;
        end
    end

    AST_LATE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_cmd == CMD_WRITE) |=> (wb_valid && wb_data == $past(wdata))); // R3

    AST_NO_SPURIOUS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_cmd != CMD_WRITE) |=> !wb_valid); // R3

endmodule

// File: rtl/lw_sram_array.sv
// Module: byte-lane storage array.
// One write port per lane, driven by the late-write buffer, and an
// asynchronous read port addressed by stage 1. Storage is not reset;
// the contents are defined only after a location has been written.
module lw_sram_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LANES-1:0]  wr_lane_we,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem_q [DEPTH];

        // Commit this lane when the pending write enables it
        always_ff @(posedge clk) begin
            if (wr_en && wr_lane_we[g]) begin
                mem_q[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
            end
        end

        // Read this lane at the stage-1 address
        assign rd_data[g*LANE_W +: LANE_W] = mem_q[rd_addr];
    end

endmodule

// File: rtl/lw_sram_rdpath.sv
// Module: read path with lane-wise forwarding and the output register.
// Merges the array word with a pending late write to the same address,
// then loads the output register on a read. Any other command clears the
// valid flag and leaves the data held.
module lw_sram_rdpath
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cmd_e              s1_cmd,
    input  logic [ADDR_W-1:0] s1_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    input  logic              wb_valid,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic [LANES-1:0]  wb_lane_we,
    input  logic [DATA_W-1:0] wb_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    logic              addr_hit;
    logic [DATA_W-1:0] fwd_data;

    // Detect a pending write to the address being read
    assign addr_hit = wb_valid && (wb_addr == s1_addr);

    for (genvar g = 0; g < LANES; g++) begin : g_fwd
        assign fwd_data[g*LANE_W +: LANE_W] = (addr_hit && wb_lane_we[g])
            ? wb_data[g*LANE_W +: LANE_W]
            : mem_rd_data[g*LANE_W +: LANE_W];
    end

    // Output register: load on read, otherwise turn the output off and hold the data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (s1_cmd == CMD_READ) begin
            out_valid <= 1'b1;
            out_data  <= fwd_data;
        end else begin
            out_valid <= 1'b0;
        end
    end

    AST_READ_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_cmd == CMD_READ) |=> out_valid); // R1

    AST_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_cmd != CMD_READ) |=> (!out_valid && $stable(out_data))); // R6

    AST_FULL_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_cmd == CMD_READ && wb_valid && wb_addr == s1_addr && (&wb_lane_we))
        |=> (out_data == $past(wb_data))); // R9

endmodule

// File: rtl/lw_sram_ctrl.sv
// Module: late-write, pipelined-read SRAM front end (top).
// Chains command capture, the late-write buffer, the array and the read
// path. rdata_oe stands in for a three-state enable: it follows the output
// register's valid flag, gated without a clock by oe_n and sleep.
module lw_sram_ctrl
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int DATA_W = LANES * LANE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              we_n,
    input  logic [LANES-1:0]  be_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              oe_n,
    input  logic              sleep,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_oe
);

    cmd_e              s1_cmd;
    logic [ADDR_W-1:0] s1_addr;
    logic [LANES-1:0]  s1_be_n;
    logic              wb_valid;
    logic [ADDR_W-1:0] wb_addr;
    logic [LANES-1:0]  wb_lane_we;
    logic [DATA_W-1:0] wb_data;
    logic [DATA_W-1:0] mem_rd_data;
    logic              out_valid;

    lw_sram_cmd #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .sleep   (sleep),
        .sel_n   (sel_n),
        .we_n    (we_n),
        .be_n    (be_n),
        .addr    (addr),
        .s1_cmd  (s1_cmd),
        .s1_addr (s1_addr),
        .s1_be_n (s1_be_n)
    );

    lw_sram_wbuf #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wbuf (
        .clk        (clk),
        .rst_n      (rst_n),
        .s1_cmd     (s1_cmd),
        .s1_addr    (s1_addr),
        .s1_be_n    (s1_be_n),
        .wdata      (wdata),
        .wb_valid   (wb_valid),
        .wb_addr    (wb_addr),
        .wb_lane_we (wb_lane_we),
        .wb_data    (wb_data)
    );

    lw_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk        (clk),
        .wr_en      (wb_valid),
        .wr_addr    (wb_addr),
        .wr_lane_we (wb_lane_we),
        .wr_data    (wb_data),
        .rd_addr    (s1_addr),
        .rd_data    (mem_rd_data)
    );

    lw_sram_rdpath #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_rdpath (
        .clk         (clk),
        .rst_n       (rst_n),
        .s1_cmd      (s1_cmd),
        .s1_addr     (s1_addr),
        .mem_rd_data (mem_rd_data),
        .wb_valid    (wb_valid),
        .wb_addr     (wb_addr),
        .wb_lane_we  (wb_lane_we),
        .wb_data     (wb_data),
        .out_valid   (out_valid),
        .out_data    (rdata)
    );

    // Output enable flag: valid data, gated at once by oe_n and sleep
    assign rdata_oe = out_valid && !oe_n && !sleep;

    AST_DESELECT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && sel_n) |-> ##2 !rdata_oe); // R6

    AST_WRITE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !sel_n && !we_n) |-> ##2 !rdata_oe); // R7

    AST_RESET_OFF: assert property (@(posedge clk)
        !rst_n |=> (!rdata_oe && !wb_valid)); // R10

endmodule

// File: tb/lw_sram_ctrl_bench.sv
`timescale 1ns/100ps
// Scoreboard bench: the driver task queues one expected item per cycle it
// drives; the monitor takes each item half a cycle after its due edge.
module lw_sram_ctrl_bench;

    localparam int AW = 8;
    localparam int DW = 36;
    localparam int K_DESEL = 0;
    localparam int K_READ  = 1;
    localparam int K_WRITE = 2;

    typedef struct {
        int          due;
        bit          is_rd;
        logic [DW-1:0] exp;
        string       tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_n = 1'b1;
    logic          we_n = 1'b1;
    logic [3:0]    be_n = 4'hF;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          oe_n = 1'b1;
    logic          sleep = 1'b0;
    logic [DW-1:0] rdata;
    logic          rdata_oe;

    int            edge_cnt = 0;
    int            n_checks = 0;
    int            n_fail = 0;
    item_t         sb_q[$];
    logic [DW-1:0] ref_mem [1 << AW];
    bit            pend_v = 1'b0;
    logic [AW-1:0] pend_a;
    logic [3:0]    pend_b;
    logic [DW-1:0] pend_d;

    lw_sram_ctrl u_lw_sram_ctrl (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .we_n(we_n), .be_n(be_n),
        .addr(addr), .wdata(wdata), .oe_n(oe_n), .sleep(sleep),
        .rdata(rdata), .rdata_oe(rdata_oe)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) edge_cnt <= edge_cnt + 1;

    task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at edge %0d", tag, act, exp, edge_cnt);
        end
    endtask

    // Driver: set inputs for the next edge and queue what must appear one edge later
    task automatic op(input int kind, input int a, input logic [3:0] b,
                      input logic [DW-1:0] d, input logic oe, input logic slp,
                      input string tag);
        item_t it;
        @(negedge clk);
        sel_n = (kind == K_DESEL);
        we_n  = (kind != K_WRITE);
        be_n  = b;
        addr  = AW'(a);
        oe_n  = oe;
        sleep = slp;
        if (pend_v) begin
            wdata = pend_d;
            for (int i = 0; i < 4; i++)
                if (!pend_b[i]) ref_mem[pend_a][i*9 +: 9] = pend_d[i*9 +: 9];
        end else begin
            wdata = {4{9'h1A5}};
        end
        pend_v = (kind == K_WRITE) && !slp;
        pend_a = AW'(a);
        pend_b = b;
        pend_d = d;
        it.due   = edge_cnt + 2;
        it.is_rd = (kind == K_READ) && !slp;
        it.exp   = ref_mem[AW'(a)];
        it.tag   = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compare each queued item in the middle of its due cycle
    initial begin
        forever begin
            @(negedge clk);
            #0.2;
            if (sb_q.size() > 0 && sb_q[0].due == edge_cnt) begin
                item_t it;
                bit exp_oe;
                it = sb_q.pop_front();
                exp_oe = it.is_rd && !oe_n && !sleep;
                check(rdata_oe == exp_oe, {it.tag, " oe"}, DW'(rdata_oe), DW'(exp_oe));
                if (exp_oe) check(rdata === it.exp, {it.tag, " data"}, rdata, it.exp);
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < (1 << AW); i++) ref_mem[i] = '0;
        oe_n = 1'b0;
        repeat (3) @(negedge clk);
        #0.2;
        // R10: output off while held in reset and right after it
        check(rdata_oe == 1'b0, "R10 reset", DW'(rdata_oe), '0);
        rst_n = 1'b1;
        @(negedge clk); #0.2;
        check(rdata_oe == 1'b0, "R10 after reset", DW'(rdata_oe), '0);

        // R3 / R1: full write then later read
        op(K_WRITE, 5, 4'b0000, 36'h123456789, 0, 0, "R7 write");
        op(K_DESEL, 0, 4'hF, '0, 0, 0, "R6 desel");
        op(K_DESEL, 0, 4'hF, '0, 0, 0, "R6 desel");
        op(K_READ,  5, 4'hF, '0, 0, 0, "R1 read");
        // R4: partial write, lanes 0 and 2 only
        op(K_WRITE, 5, 4'b1010, 36'hABCDEF012, 0, 0, "R4 write");
        op(K_DESEL, 0, 4'hF, '0, 0, 0, "R6 desel");
        op(K_DESEL, 0, 4'hF, '0, 0, 0, "R6 desel");
        op(K_READ,  5, 4'hF, '0, 0, 0, "R4 read");
        // R5: abort write leaves data
        op(K_WRITE, 5, 4'b1111, 36'hFFFFFFFFF, 0, 0, "R5 write");
        op(K_DESEL, 0, 4'hF, '0, 0, 0, "R6 desel");
        op(K_DESEL, 0, 4'hF, '0, 0, 0, "R6 desel");
        op(K_READ,  5, 4'hF, '0, 0, 0, "R5 read");
        // R9: read on the edge right after the write command, full and partial
        op(K_WRITE, 7, 4'b0000, 36'h0F0F0F0F0, 0, 0, "R9 write");
        op(K_READ,  7, 4'hF, '0, 0, 0, "R9 read full");
        op(K_WRITE, 7, 4'b0110, 36'h555555555, 0, 0, "R9 write");
        op(K_READ,  7, 4'hF, '0, 0, 0, "R9 read partial");
        op(K_WRITE, 9, 4'b0000, 36'h222222222, 0, 0, "R9 write");
        op(K_WRITE, 7, 4'b1110, 36'h333333333, 0, 0, "R9 write");
        op(K_READ,  9, 4'hF, '0, 0, 0, "R9 read older");
        op(K_READ,  7, 4'hF, '0, 0, 0, "R9 read newer");
        // R3: write data taken on the following edge only
        op(K_WRITE, 11, 4'b0000, 36'h0000000AA, 0, 0, "R3 write");
        op(K_READ,  11, 4'hF, '0, 0, 0, "R3 read");

        // R2: oe_n gates the flag at once and leaves the data register alone
        op(K_READ,  5, 4'hF, '0, 0, 0, "R2 read");
        op(K_DESEL, 0, 4'hF, '0, 1, 0, "R6 desel");
        op(K_DESEL, 0, 4'hF, '0, 1, 0, "R6 desel");
        #0.5 oe_n = 1'b0;
        #0.3;
        check(rdata_oe == 1'b1, "R2 oe low", DW'(rdata_oe), DW'(1));
        check(rdata === ref_mem[5], "R2 data held", rdata, ref_mem[5]);
        #0.2 oe_n = 1'b1;
        #0.2;
        check(rdata_oe == 1'b0, "R2 oe high", DW'(rdata_oe), '0);

        // R8: sleep turns output off and ignores commands
        op(K_READ,  5, 4'hF, '0, 0, 0, "R8 read");
        op(K_DESEL, 0, 4'hF, '0, 0, 0, "R6 desel");
        op(K_WRITE, 5, 4'b0000, 36'hDEADBEEF0, 0, 1, "R8 sleep write");
        op(K_READ,  5, 4'hF, '0, 0, 1, "R8 sleep read");
        op(K_DESEL, 0, 4'hF, '0, 0, 1, "R8 sleep");
        op(K_DESEL, 0, 4'hF, '0, 0, 0, "R8 wake");
        op(K_READ,  5, 4'hF, '0, 0, 0, "R8 kept");

        // Random mix over preloaded addresses
        for (int i = 0; i < 8; i++)
            op(K_WRITE, 32 + i, 4'b0000, {4'h0, $urandom}, 0, 0, "R3 preload");
        for (int i = 0; i < 300; i++) begin
            int k;
            k = $urandom_range(2);
            op(k, 32 + $urandom_range(7), 4'($urandom), {$urandom, 4'($urandom)},
               1'($urandom_range(3) == 0), 0,
               (k == K_READ) ? "R9 rand read" : (k == K_WRITE) ? "R7 rand write" : "R6 rand desel");
        end
        op(K_DESEL, 0, 4'hF, '0, 0, 0, "R6 drain");
        op(K_DESEL, 0, 4'hF, '0, 0, 0, "R6 drain");
        repeat (3) @(negedge clk);
        #0.5;
        check(sb_q.size() == 0, "R1 queue drained", DW'(sb_q.size()), '0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule